// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block resolves read-after-write hazards for a six-stage in-order scalar pipeline (fetch, decode, register read, execute, memory, write-back). Each cycle it compares the two source register numbers of the instruction in the register-read stage with the destination numbers of the instructions one stage ahead (execute) and two stages ahead (memory). The comparison results are captured in registers. In the following cycle they steer the two operand multiplexers that feed the execute stage, because that is when the dependent instruction enters execute.

When the producer is one stage ahead and is not a load, its value comes from the execute-stage result latch. When the producer is two stages ahead, the value comes from one of two separate buffers at the end of the memory stage: the buffered arithmetic result, or the data returned from the data cache. The producer's load flag picks between them. When the instruction in execute is a load and its destination is read by the instruction in register-read, the block holds the three front stages for one cycle and inserts a bubble into execute. After that cycle the loaded value arrives from the memory-stage data buffer. A dependence three instructions apart needs no path, because the register file writes before it reads.

Top module: `fwd_interlock_unit`

## Requirements
- R1: After a synchronous reset, and in the cycle that follows a reset cycle, both operand outputs equal the register-file inputs (`rf_a`, `rf_b`) and `hold_front` and `kill_alu` are low.
- R2: If a valid register-read instruction has a source that matches the destination of a non-load execute-stage producer with write enable high, that operand equals `near_data` in the next cycle.
- R3: If a source matches only the memory-stage producer, the producer's write enable is high and it is not a load, that operand equals `far_alu_data` in the next cycle.
- R4: If a source matches only the memory-stage producer and the producer is a load, that operand equals `far_load_data` in the next cycle.
- R5: If both producers write the register that a source reads, the execute-stage (younger) producer supplies the value.
- R6: A match on register 0, or a match with a producer whose write enable is low, causes no forwarding and no stall.
- R7: If the execute-stage instruction is a load with write enable high, and a valid register-read source names its nonzero destination, then `hold_front` and `kill_alu` are high in that same cycle. In the next cycle both operands equal the register-file inputs, because the bubble enters execute.
- R8: Once the bubble has entered execute and the load has moved to memory, the stall drops. The waiting instruction then receives the load value through `far_load_data` on the next cycle, so the stall lasts exactly one cycle.
- R9: The two operands are routed independently. In one cycle operand A can take one producer's path while operand B takes the other producer's path.
- R10: When `rd_valid` is low, no forwarding path is selected and no stall is raised, whatever the register numbers are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Register-read stage holds a real instruction |
| rd_src_a | input | 5 | First source register of the register-read instruction |
| rd_src_b | input | 5 | Second source register of the register-read instruction |
| ex_dst | input | 5 | Destination of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| rf_a | input | 32 | Register-file value for operand A of the instruction in execute |
| rf_b | input | 32 | Register-file value for operand B of the instruction in execute |
| near_data | input | 32 | Execute-stage output latch (result of the instruction now in memory) |
| far_alu_data | input | 32 | Memory-stage buffer holding the previous arithmetic result |
| far_load_data | input | 32 | Memory-stage buffer holding data returned by the data cache |
| op_a | output | 32 | Selected operand A for the execute stage |
| op_b | output | 32 | Selected operand B for the execute stage |
| hold_front | output | 1 | Hold the fetch, decode and register-read stages this cycle |
| kill_alu | output | 1 | Insert a bubble (valid and write enable cleared) into execute |

## Verification
The hardest situation to reach from the ports is the load-use sequence. It needs the stall, then a bubble cycle in which the same register-read instruction is presented again while the load has moved to the memory stage, and then the load-data path on the cycle after. The stimulus table drives this as two consecutive rows that model the pipeline's own reaction: the second row repeats the register-read specifiers, clears the execute-stage write enable, and moves the load's destination into the memory-stage fields. A second hard case is a reset that arrives while a forwarding select is pending. A directed test sets up a near match and asserts reset on that same edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF      = 2'd0,
    SRC_NEAR    = 2'd1,
    SRC_FAR_ALU = 2'd2,
    SRC_FAR_LD  = 2'd3
  } opnd_src_e;
endpackage

// File: rtl/spec_match.sv
module spec_match #(
  parameter int AW = 5
) (
  input  logic          valid,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);
  // register 0 is hard-wired and never forwarded
  always_comb begin
    hit = valid && wen && (dst == src) && (dst != '0);
  end
endmodule

// File: rtl/operand_route.sv
module operand_route
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          valid,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  output opnd_src_e     next_sel,
  output logic          load_hazard
);
  localparam int NPROD = 2;

  logic [NPROD-1:0][AW-1:0] prod_dst;
  logic [NPROD-1:0]         prod_wen;
  logic [NPROD-1:0]         hit;

  assign prod_dst[0] = ex_dst;
  assign prod_dst[1] = mem_dst;
  assign prod_wen[0] = ex_wen;
  assign prod_wen[1] = mem_wen;

  for (genvar p = 0; p < NPROD; p++) begin : g_cmp
    spec_match #(.AW(AW)) cmp_i (
      .valid(valid),
      .src  (src),
      .dst  (prod_dst[p]),
      .wen  (prod_wen[p]),
      .hit  (hit[p])
    );
  end

  // nearer producer has priority; a near load cannot forward yet
  always_comb begin
    load_hazard = hit[0] && ex_is_load;
    if (hit[0]) begin
      next_sel = ex_is_load ? SRC_RF : SRC_NEAR;
    end else if (hit[1]) begin
      next_sel = mem_is_load ? SRC_FAR_LD : SRC_FAR_ALU;
    end else begin
      next_sel = SRC_RF;
    end
  end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  opnd_src_e     sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] near_val,
  input  logic [DW-1:0] far_alu_val,
  input  logic [DW-1:0] far_ld_val,
  output logic [DW-1:0] out_val
);
  always_comb begin
    unique case (sel)
      SRC_NEAR:    out_val = near_val;
      SRC_FAR_ALU: out_val = far_alu_val;
      SRC_FAR_LD:  out_val = far_ld_val;
      default:     out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
  import fwd_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_src_a,
  input  logic [AW-1:0]     rd_src_b,
  input  logic [AW-1:0]     ex_dst,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [AW-1:0]     mem_dst,
  input  logic              mem_wen,
  input  logic              mem_is_load,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] near_data,
  input  logic [DATA_W-1:0] far_alu_data,
  input  logic [DATA_W-1:0] far_load_data,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic              hold_front,
  output logic              kill_alu
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][AW-1:0]     src;
  logic [NOPND-1:0][DATA_W-1:0] rf_val;
  logic [NOPND-1:0][DATA_W-1:0] op_val;
  logic [NOPND-1:0]             hazard;
  opnd_src_e                    next_sel [NOPND];
  opnd_src_e                    sel_q    [NOPND];
  logic                         stall;

  assign src[0]    = rd_src_a;
  assign src[1]    = rd_src_b;
  assign rf_val[0] = rf_a;
  assign rf_val[1] = rf_b;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    operand_route #(.AW(AW)) route_i (
      .valid      (rd_valid),
      .src        (src[k]),
      .ex_dst     (ex_dst),
      .ex_wen     (ex_wen),
      .ex_is_load (ex_is_load),
      .mem_dst    (mem_dst),
      .mem_wen    (mem_wen),
      .mem_is_load(mem_is_load),
      .next_sel   (next_sel[k]),
      .load_hazard(hazard[k])
    );

    // the bubble entering execute during a stall takes no path
    always_ff @(posedge clk) begin
      if (rst || stall) begin
        sel_q[k] <= SRC_RF;
      end else begin
        sel_q[k] <= next_sel[k];
      end
    end

    operand_mux #(.DW(DATA_W)) mux_i (
      .sel        (sel_q[k]),
      .rf_val     (rf_val[k]),
      .near_val   (near_data),
      .far_alu_val(far_alu_data),
      .far_ld_val (far_load_data),
      .out_val    (op_val[k])
    );
  end

  assign stall      = |hazard;
  assign hold_front = stall;
  assign kill_alu   = stall;
  assign op_a       = op_val[0];
  assign op_b       = op_val[1];
endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_valid,
  input logic [AW-1:0] rd_src_a,
  input logic [AW-1:0] rd_src_b,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wen,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_dst,
  input logic [DW-1:0] rf_a,
  input logic [DW-1:0] rf_b,
  input logic [DW-1:0] near_data,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          hold_front,
  input logic          kill_alu
);
  // R7
  stall_src_chk: assert property (@(posedge clk) disable iff (rst)
    hold_front |-> (ex_is_load && ex_wen && rd_valid && ex_dst != '0));

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> !hold_front && !kill_alu);

  // R7
  bubble_rf_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hold_front)) |-> (op_a == rf_a && op_b == rf_b));

  // R2
  near_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_valid && ex_wen && !ex_is_load &&
      ex_dst != '0 && ex_dst == rd_src_a)) |-> (op_a == near_data));

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_src_b == '0)) |-> (op_b == rf_b));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (op_a == rf_a && op_b == rf_b));

  // mem_dst is part of the observed interface only
  logic unused_mem;
  assign unused_mem = ^mem_dst;
endmodule

bind fwd_interlock_unit fwd_interlock_chk #(.AW(AW), .DW(DATA_W)) chk_i (.*);

// File: tb/fwd_interlock_unit_tb.sv
module fwd_interlock_unit_tb_top;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [DW-1:0] V_RFA  = 32'h1111_0001;
  localparam logic [DW-1:0] V_RFB  = 32'h2222_0002;
  localparam logic [DW-1:0] V_NEAR = 32'hAAAA_0003;
  localparam logic [DW-1:0] V_FALU = 32'hBBBB_0004;
  localparam logic [DW-1:0] V_FLD  = 32'hCCCC_0005;

  // expected source codes: 0 rf, 1 near, 2 far arithmetic, 3 far load
  typedef struct packed {
    logic          rv;
    logic [AW-1:0] sa, sb, ed;
    logic          ew, el;
    logic [AW-1:0] md;
    logic          mw, ml;
    logic          st;
    logic [1:0]    ea, eb;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd10}, // R10
    '{1'b1, 5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 4'd2},  // R2
    '{1'b1, 5'd6,  5'd7,  5'd9,  1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 4'd3},  // R3
    '{1'b1, 5'd8,  5'd1,  5'd2,  1'b1, 1'b0, 5'd8,  1'b1, 1'b1, 1'b0, 2'd3, 2'd0, 4'd4},  // R4
    '{1'b1, 5'd5,  5'd5,  5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 1'b1, 1'b0, 2'd1, 2'd1, 4'd5},  // R5
    '{1'b1, 5'd10, 5'd11, 5'd10, 1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 4'd9},  // R9
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd6},  // R6
    '{1'b1, 5'd12, 5'd13, 5'd12, 1'b0, 1'b1, 5'd13, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 4'd6},  // R6
    '{1'b0, 5'd14, 5'd16, 5'd14, 1'b1, 1'b1, 5'd16, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd10}, // R10
    '{1'b1, 5'd20, 5'd15, 5'd15, 1'b1, 1'b1, 5'd20, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 4'd7},  // R7
    '{1'b1, 5'd20, 5'd15, 5'd0,  1'b0, 1'b0, 5'd15, 1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 4'd8},  // R8
    '{1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_src_a = '0, rd_src_b = '0, ex_dst = '0, mem_dst = '0;
  logic ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, mem_is_load = 1'b0;
  logic [DW-1:0] op_a, op_b;
  logic hold_front, kill_alu;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fwd_interlock_unit dut_i (
    .clk(clk), .rst(rst), .rd_valid(rd_valid),
    .rd_src_a(rd_src_a), .rd_src_b(rd_src_b),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .rf_a(V_RFA), .rf_b(V_RFB), .near_data(V_NEAR),
    .far_alu_data(V_FALU), .far_load_data(V_FLD),
    .op_a(op_a), .op_b(op_b), .hold_front(hold_front), .kill_alu(kill_alu)
  );

  function automatic logic [DW-1:0] code_val(input logic [1:0] c, input logic [DW-1:0] rfv);
    case (c)
      2'd1:    return V_NEAR;
      2'd2:    return V_FALU;
      2'd3:    return V_FLD;
      default: return rfv;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rd_valid = v.rv; rd_src_a = v.sa; rd_src_b = v.sb;
    ex_dst = v.ed; ex_wen = v.ew; ex_is_load = v.el;
    mem_dst = v.md; mem_wen = v.mw; mem_is_load = v.ml;
  endtask

  task automatic idle();
    drive('0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    idle();
    repeat (3) @(negedge clk);
    // R1: state while reset is asserted and just after
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "op_a after reset", op_a, V_RFA);
    check("R1", "op_b after reset", op_b, V_RFB);
    check("R1", "hold_front after reset", {31'd0, hold_front}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check($sformatf("R%0d", TBL[i-1].req), "op_a", op_a, code_val(TBL[i-1].ea, V_RFA));
        check($sformatf("R%0d", TBL[i-1].req), "op_b", op_b, code_val(TBL[i-1].eb, V_RFB));
      end
      drive(TBL[i]);
      #1;
      check($sformatf("R%0d", TBL[i].req), "hold_front", {31'd0, hold_front}, {31'd0, TBL[i].st});
      check($sformatf("R%0d", TBL[i].req), "kill_alu", {31'd0, kill_alu}, {31'd0, TBL[i].st});
    end
    @(negedge clk);
    check("R8", "op_a last", op_a, code_val(TBL[NV-1].ea, V_RFA));
    check("R8", "op_b last", op_b, code_val(TBL[NV-1].eb, V_RFB));

    // R1: reset on the same edge as a pending near match wins
    drive('{1'b1, 5'd9, 5'd9, 5'd9, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd1});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle();
    #1;
    check("R1", "op_a after reset with match", op_a, V_RFA);
    check("R1", "op_b after reset with match", op_b, V_RFB);

    // R7: load-use on operand A, stall seen in the same cycle
    @(negedge clk);
    drive('{1'b1, 5'd17, 5'd2, 5'd17, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd7});
    #1;
    check("R7", "hold_front load-use A", {31'd0, hold_front}, 32'd1);
    // R8: bubble in execute, load now in memory
    @(negedge clk);
    check("R7", "op_a bubble", op_a, V_RFA);
    drive('{1'b1, 5'd17, 5'd2, 5'd0, 1'b0, 1'b0, 5'd17, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 4'd8});
    #1;
    check("R8", "hold_front released", {31'd0, hold_front}, 32'd0);
    @(negedge clk);
    check("R8", "op_a load data", op_a, V_FLD);
    check("R8", "op_b untouched", op_b, V_RFB);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule